// File: doc/BRIEF.md
# Pipelined Burst SRAM With Zero Turnaround

This block is a synthesizable, cycle-accurate model of a synchronous burst SRAM in which reads and writes share one pipeline depth. Every command enters on a rising clock edge. A read returns its word two enabled edges after its address was taken. A write collects its data on the bus at the same point. Because both directions line up, any mix of reads and writes can follow one another on consecutive cycles with no idle slot between them.

The data word has four 9-bit lanes, each with its own active-low write mask. A load cycle starts a new access at a given address. An advance cycle continues the last access internally through a group of four words. The word order within the group follows a static strap and is either linear or interleaved. A clock-enable input can freeze the whole block. A sleep input refuses new commands. An output-enable input blanks the read-valid flag without a clock. The array depth is a parameter, so simulation can use a small memory.

Top module: `pipelined_burst_sram`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises, `rvalid` is 0. No operation is in flight.
- R2: Take a read command (`load_n`=0, `we_n`=1, valid select, `sleep`=0) registered on enabled edge k. After enabled edge k+2, `rdata` holds the addressed word and `rvalid` is 1, provided `out_en_n` is 0.
- R3: Take a write command registered on enabled edge k. The write takes `wdata` on enabled edge k+2. In the output slot after edge k+2, `rvalid` is 0.
- R4: Lane i occupies `wdata`/`rdata` bits [9i+8:9i]. A write stores lane i only when `bw_n[i]`=0. The other lanes keep their old contents.
- R5: A load cycle is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other combination is a deselect. A deselect performs no access, changes no memory, gives `rvalid`=0 in its slot, and ends any running burst.
- R6: With `order_linear`=1, the n-th advance after a load at address A accesses A with its two low bits replaced by (A[1:0]+n) mod 4.
- R7: With `order_linear`=0, the n-th advance accesses A with its two low bits replaced by A[1:0] XOR (n mod 4).
- R8: An advance cycle (`load_n`=1) repeats the read or write type of the last load. It keeps cycling through the same group of four words. When no burst is running, it does nothing.
- R9: On an edge where `clk_en_n` is 1, nothing changes. The command inputs are ignored, no write happens, and `rdata` holds its value.
- R10: While `sleep` is 1, no command is accepted and the memory is not changed. Operations already in flight still complete.
- R11: While `out_en_n` is 1, `rvalid` is 0. This takes effect without a clock.
- R12: Reads and writes can alternate on consecutive cycles. A read issued on the cycle after a write to the same address returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the pipeline and burst state |
| clk_en_n | input | 1 | Active-low clock enable; when high, the edge is ignored |
| sleep | input | 1 | Snooze request; blocks new commands |
| load_n | input | 1 | Low: load a new address; high: advance the burst |
| we_n | input | 1 | Low: write command; high: read command (on load cycles) |
| cs1_n | input | 1 | Active-low select term |
| cs2 | input | 1 | Active-high select term |
| cs3_n | input | 1 | Active-low select term |
| bw_n | input | LANES | Per-lane active-low write mask |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, taken two enabled edges after its command |
| order_linear | input | 1 | Burst order strap: 1 linear, 0 interleaved |
| out_en_n | input | 1 | Active-low output enable |
| rdata | output | LANES*LANE_W | Registered read data |
| rvalid | output | 1 | Read data valid flag |

## Verification
The hardest cases to reach from the ports are pipeline states in which operations of both kinds are in flight while the memory is being changed. Examples are a read that follows a write to the same word by one cycle, and a burst frozen by the clock enable midway with a conflicting command held on the inputs. The bench keeps its own copy of the burst position and of the memory. Through one driver task it issues dense sequences in which reads, writes, advances, deselects, stalls and sleep cycles are interleaved. Each slot queues the output that the requirements predict for it, so every cycle after such a sequence is compared, including the slots where no data is expected.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int LANES   = 4;
    localparam int LANE_W  = 9;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low address bits for a given step of a burst
    function automatic logic [BURST_W-1:0] burst_lo(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] step,
        input logic               linear
    );
        logic [BURST_W-1:0] sum;
        sum = start + step;
        return linear ? sum : (start ^ step);
    endfunction

endpackage

// File: rtl/psram_sequencer.sv
module psram_sequencer
    import psram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sleep,
    input  logic              load_n,
    input  logic              we_n,
    input  logic              selected,
    input  logic              linear,
    input  logic [ADDR_W-1:0] addr,
    output op_e               issue_op,
    output logic [ADDR_W-1:0] issue_addr
);
    localparam int HI_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic               active;
        logic               is_wr;
        logic [HI_W-1:0]    base;
        logic [BURST_W-1:0] start;
        logic [BURST_W-1:0] step;
    } seq_t;

    seq_t               seq_d, seq_q;
    logic [BURST_W-1:0] step_n;

    always_comb begin
        seq_d      = seq_q;
        issue_op   = OP_NONE;
        issue_addr = addr;
        step_n     = seq_q.step + 1'b1;
        if (!sleep) begin
            if (!load_n) begin
                if (selected) begin
                    seq_d.active = 1'b1;
                    seq_d.is_wr  = ~we_n;
                    seq_d.base   = addr[ADDR_W-1:BURST_W];
                    seq_d.start  = addr[BURST_W-1:0];
                    seq_d.step   = '0;
                    issue_op     = we_n ? OP_READ : OP_WRITE;
                end else begin
                    seq_d.active = 1'b0;
                end
            end else if (seq_q.active) begin
                seq_d.step = step_n;
                issue_op   = seq_q.is_wr ? OP_WRITE : OP_READ;
                issue_addr = {seq_q.base, burst_lo(seq_q.start, step_n, linear)};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else if (enable) begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/psram_array.sv
module psram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        be_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !be_n[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end

endmodule

// File: rtl/psram_pipe.sv
module psram_pipe
    import psram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int DW     = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  op_e               issue_op,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [LANES-1:0]  issue_bw_n,
    input  logic [DW-1:0]     mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be_n,
    output logic [DW-1:0]     dout,
    output logic              dvalid
);
    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  bw_n;
    } stage_t;

    typedef struct packed {
        stage_t        s1;
        stage_t        s2;
        logic [DW-1:0] dout;
        logic          dvalid;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.s1.op   = issue_op;
        pipe_d.s1.addr = issue_addr;
        pipe_d.s1.bw_n = issue_bw_n;
        pipe_d.s2      = pipe_q.s1;
        pipe_d.dvalid  = (pipe_q.s2.op == OP_READ);
        if (pipe_q.s2.op == OP_READ) begin
            pipe_d.dout = mem_rdata;
        end
        mem_we   = enable && (pipe_q.s2.op == OP_WRITE);
        mem_addr = pipe_q.s2.addr;
        mem_be_n = pipe_q.s2.bw_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else if (enable) begin
            pipe_q <= pipe_d;
        end
    end

    assign dout   = pipe_q.dout;
    assign dvalid = pipe_q.dvalid;

endmodule

// File: rtl/pipelined_burst_sram.sv
module pipelined_burst_sram
    import psram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = psram_pkg::LANES,
    parameter int LANE_W = psram_pkg::LANE_W,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              sleep,
    input  logic              load_n,
    input  logic              we_n,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              order_linear,
    input  logic              out_en_n,
    output logic [DW-1:0]     rdata,
    output logic              rvalid
);
    logic              enable;
    logic              selected;
    op_e               issue_op;
    logic [ADDR_W-1:0] issue_addr;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [LANES-1:0]  mem_be_n;
    logic [DW-1:0]     mem_rdata;
    logic              dvalid;

    assign enable   = ~clk_en_n;
    assign selected = ~cs1_n & cs2 & ~cs3_n;

    psram_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .sleep      (sleep),
        .load_n     (load_n),
        .we_n       (we_n),
        .selected   (selected),
        .linear     (order_linear),
        .addr       (addr),
        .issue_op   (issue_op),
        .issue_addr (issue_addr)
    );

    psram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .DW(DW)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .issue_op   (issue_op),
        .issue_addr (issue_addr),
        .issue_bw_n (bw_n),
        .mem_rdata  (mem_rdata),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_be_n   (mem_be_n),
        .dout       (rdata),
        .dvalid     (dvalid)
    );

    psram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .be_n  (mem_be_n),
        .wdata (wdata),
        .rdata (mem_rdata)
    );

    assign rvalid = dvalid & ~out_en_n;

endmodule

// File: rtl/psram_checker.sv
module psram_checker #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en_n,
    input logic          sleep,
    input logic          load_n,
    input logic          we_n,
    input logic          cs1_n,
    input logic          cs2,
    input logic          cs3_n,
    input logic          out_en_n,
    input logic [DW-1:0] rdata,
    input logic          rvalid
);
    logic [2:0] since_rst;
    logic       en, sel_ok, rd_cmd, wr_cmd, desel_cmd, sleep_cmd, warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 3'd7) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    assign en        = ~clk_en_n;
    assign sel_ok    = ~cs1_n & cs2 & ~cs3_n;
    assign rd_cmd    = en & ~sleep & ~load_n & sel_ok & we_n;
    assign wr_cmd    = en & ~sleep & ~load_n & sel_ok & ~we_n;
    assign desel_cmd = en & ~sleep & ~load_n & ~sel_ok;
    assign sleep_cmd = en & sleep;
    assign warm      = (since_rst >= 3'd4);

    AST_OE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rvalid); // R11

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd1 && clk_en_n) |=> $stable(rdata)); // R9

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(rd_cmd, 3) && $past(en, 2) && $past(en, 1) && !out_en_n) |-> rvalid); // R2

    AST_WRITE_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(wr_cmd, 3) && $past(en, 2) && $past(en, 1)) |-> !rvalid); // R3

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(desel_cmd, 3) && $past(en, 2) && $past(en, 1)) |-> !rvalid); // R5

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(sleep_cmd, 3) && $past(en, 2) && $past(en, 1)) |-> !rvalid); // R10

endmodule

bind pipelined_burst_sram psram_checker #(.DW(DW)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .sleep    (sleep),
    .load_n   (load_n),
    .we_n     (we_n),
    .cs1_n    (cs1_n),
    .cs2      (cs2),
    .cs3_n    (cs3_n),
    .out_en_n (out_en_n),
    .rdata    (rdata),
    .rvalid   (rvalid)
);

// File: tb/pipelined_burst_sram_test.sv
module pipelined_burst_sram_test;
    localparam int AW = 6;
    localparam int DW = 36;
    localparam logic [2:0] SEL = 3'b010;
    localparam logic [2:0] OFF = 3'b110;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          sleep = 1'b0;
    logic          load_n = 1'b0;
    logic          we_n = 1'b1;
    logic          cs1_n = 1'b1;
    logic          cs2 = 1'b1;
    logic          cs3_n = 1'b0;
    logic [3:0]    bw_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          order_linear = 1'b1;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    pipelined_burst_sram #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sleep(sleep),
        .load_n(load_n), .we_n(we_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .bw_n(bw_n), .addr(addr), .wdata(wdata), .order_linear(order_linear),
        .out_en_n(out_en_n), .rdata(rdata), .rvalid(rvalid)
    );

    always #5 clk = ~clk;

    typedef struct {
        int            due;
        bit            v;
        logic [DW-1:0] d;
        int            req;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] wd_sched[int];
    logic [DW-1:0] ref_mem[1 << AW];
    int            cyc = 0;
    int            checks = 0;
    int            errors = 0;
    bit            done = 0;
    bit            b_act = 0;
    bit            b_wr = 0;
    logic [AW-3:0] b_base = '0;
    logic [1:0]    b_start = '0;
    logic [1:0]    b_step = '0;

    // enabled-edge counter kept from the ports
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else if (!clk_en_n) cyc <= cyc + 1;
    end

    function automatic logic [DW-1:0] pat(int a, int k);
        return 36'h9_A5C3_0F00 ^ (36'(a) * 36'h0_1111_1111) ^ 36'(k * 7);
    endfunction

    task automatic step(bit ce_off, bit sl, bit ld_n, bit w_n, logic [2:0] cs,
                        logic [AW-1:0] a, logic [3:0] bw, logic [DW-1:0] d,
                        bit oe_off, int req);
        bit            go;
        bit            isw;
        logic [AW-1:0] ea;
        logic [1:0]    lo;
        exp_t          e;
        go = 0; isw = 0; ea = a;
        @(negedge clk); #1;
        clk_en_n = ce_off; sleep = sl; load_n = ld_n; we_n = w_n;
        {cs1_n, cs2, cs3_n} = cs; addr = a; bw_n = bw; out_en_n = oe_off;
        wdata = wd_sched.exists(cyc) ? wd_sched[cyc] : '0;
        if (!ce_off) begin
            if (!sl) begin
                if (!ld_n) begin
                    if (cs == SEL) begin
                        b_act = 1; b_wr = !w_n; b_base = a[AW-1:2];
                        b_start = a[1:0]; b_step = 0; go = 1; isw = b_wr;
                    end else begin
                        b_act = 0;
                    end
                end else if (b_act) begin
                    b_step = b_step + 2'd1;
                    lo = order_linear ? 2'(b_start + b_step) : (b_start ^ b_step);
                    ea = {b_base, lo}; go = 1; isw = b_wr;
                end
            end
            e.due = cyc + 3; e.req = req; e.v = go && !isw; e.d = ref_mem[ea];
            if (go && isw) begin
                for (int l = 0; l < 4; l++)
                    if (!bw[l]) ref_mem[ea][9*l +: 9] = d[9*l +: 9];
                wd_sched[cyc + 2] = d;
            end
            sb.push_back(e);
        end
    endtask

    task automatic rd(logic [AW-1:0] a, int req);
        step(0, 0, 0, 1, SEL, a, 4'hF, '0, 0, req);
    endtask
    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, logic [3:0] bw, int req);
        step(0, 0, 0, 0, SEL, a, bw, d, 0, req);
    endtask
    task automatic adv(logic [DW-1:0] d, int req);
        step(0, 0, 1, 1, SEL, '0, 4'h0, d, 0, req);
    endtask
    task automatic idle(int req);
        step(0, 0, 0, 1, OFF, '0, 4'hF, '0, 0, req);
    endtask

    // monitor: compares queued expectations, and checks holding during stalls
    initial begin
        int            last;
        logic [DW-1:0] prev_d;
        last = -1; prev_d = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (cyc == last) begin
                    checks++; // R9 output frozen across a disabled edge
                    if (rdata !== prev_d) begin
                        errors++;
                        $display("FAIL R9: rdata=%h expected %h (stalled)", rdata, prev_d);
                    end
                end else begin
                    while (sb.size() > 0 && sb[0].due == cyc) begin
                        exp_t e;
                        bit   expv;
                        e = sb.pop_front();
                        expv = e.v && !out_en_n;
                        checks++;
                        if (rvalid !== expv || (expv && rdata !== e.d)) begin
                            errors++;
                            $display("FAIL R%0d: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                                     e.req, rvalid, rdata, expv, e.d);
                        end
                    end
                end
                last = cyc;
                prev_d = rdata;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++; // R1 quiet during reset
        if (rvalid !== 1'b0) begin
            errors++; $display("FAIL R1: rvalid=%0b expected 0 in reset", rvalid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++; // R1 quiet after release
        if (rvalid !== 1'b0) begin
            errors++; $display("FAIL R1: rvalid=%0b expected 0 after reset", rvalid);
        end

        // R3 writes fill, R2 reads back, back-to-back
        for (int a = 0; a < 32; a++) wr(AW'(a), pat(a, 0), 4'h0, 3);
        for (int a = 0; a < 32; a++) rd(AW'(a), 2);

        // R12 mixed traffic, read right after write of the same word
        wr(6'd20, pat(20, 1), 4'h0, 12);
        rd(6'd20, 12);
        wr(6'd21, pat(21, 1), 4'h0, 12);
        rd(6'd20, 12);
        rd(6'd21, 12);
        wr(6'd22, pat(22, 1), 4'h0, 12);
        wr(6'd23, pat(23, 1), 4'h0, 12);
        rd(6'd22, 12);

        // R4 lanes 0 and 2 written, 1 and 3 kept
        wr(6'd3, 36'hF_FFFF_FFFF, 4'b1010, 4);
        rd(6'd3, 4);

        // R5 each invalid select combination is ignored
        step(0, 0, 0, 0, 3'b000, 6'd5, 4'h0, 36'h0, 0, 5);
        step(0, 0, 0, 0, 3'b011, 6'd5, 4'h0, 36'h0, 0, 5);
        step(0, 0, 0, 0, 3'b110, 6'd5, 4'h0, 36'h0, 0, 5);
        rd(6'd5, 5);
        // R5 and R8 deselect ends a burst; advance then does nothing
        rd(6'd8, 8);
        idle(5);
        adv('0, 8);
        adv('0, 8);

        // R6 linear burst with wrap, R8 repeats read type
        order_linear = 1'b1;
        rd(6'd6, 6);
        for (int n = 0; n < 4; n++) adv('0, 6);

        // R7 interleaved reads
        order_linear = 1'b0;
        rd(6'd9, 7);
        for (int n = 0; n < 3; n++) adv('0, 7);
        // R7 and R8 interleaved write burst then read back
        wr(6'd13, pat(13, 2), 4'h0, 8);
        for (int n = 0; n < 3; n++) adv(pat(13, 3 + n), 8);
        for (int a = 12; a < 16; a++) rd(AW'(a), 7);
        order_linear = 1'b1;

        // R9 stall: conflicting write held while disabled must be ignored
        rd(6'd1, 9);
        step(1, 0, 0, 0, SEL, 6'd1, 4'h0, 36'h0, 0, 9);
        step(1, 0, 0, 0, SEL, 6'd1, 4'h0, 36'h0, 0, 9);
        idle(9);
        rd(6'd1, 9);

        // R10 sleep blocks a new write while the earlier read completes
        rd(6'd2, 10);
        step(0, 1, 0, 0, SEL, 6'd2, 4'h0, 36'h0, 0, 10);
        step(0, 1, 1, 0, SEL, 6'd2, 4'h0, 36'h0, 0, 10);
        rd(6'd2, 10);

        // R11 output enable high blanks the valid flag
        rd(6'd0, 11);
        idle(11);
        step(0, 0, 0, 1, OFF, '0, 4'hF, '0, 1, 11);
        idle(11);

        for (int n = 0; n < 6; n++) idle(1);
        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d expected results never compared, expected 0", sb.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule